// File: doc/BRIEF.md
# I/Q Ramp Test-Pattern Path

This block sits on the sample path of a two-channel (I and Q) ADC interface. Each channel has its own test-word source. The source can pass the captured samples through, or it can replace them with an incrementing ramp or with a constant all-ones word. A checker follows each source. Once it is enabled, the checker waits for a zero sample, locks onto the ramp that starts there, and counts every later sample that differs from the expected ramp value.

A typical calibration step puts the ramp on one channel and all ones on the other. It then restarts the checkers by dropping and raising the enable, waits, and reads the lock flag and error count of each channel. Then the roles of the two channels are swapped. A channel that never locked shows its lock flag low. This tells it apart from a channel that locked with no errors, and it exposes swapped I/Q lanes.

The sample stream carries a valid strobe and has no ready. An ADC cannot be stalled, so there is no back-pressure: a sample is taken on every cycle with `in_valid` high. The output stream repeats each accepted sample one cycle later, with `out_valid`. Mode, enable and status pins are plain levels.

Top module: `iq_pattern_path`

## Requirements
- R1: The mode code 0 (pass), or the unused code 3, forwards the input sample to the output of that channel one clock after it is accepted. `out_valid` is `in_valid` delayed by one clock. Output data changes only on accepted samples.
- R2: The mode code 1 (ramp) outputs 0, 1, 2, … on successive accepted samples and wraps from all ones to zero. The input data is ignored. The ramp restarts at 0 whenever the mode has been other than ramp for at least one clock.
- R3: The mode code 2 (ones) outputs all ones on every accepted sample, whatever the input data.
- R4: While `chk_en` is low, the lock flags and error counts of both checkers read 0 one clock later.
- R5: An enabled checker stays unlocked until a valid output sample equal to zero reaches it. It then reads locked from the next clock on. Samples before the lock never count as errors.
- R6: After the lock, each valid sample is compared with the expected value. The expected value is the locking zero plus one for the first sample, and after that the previous expected value plus one, wrapping. It advances whether or not the sample matched. Each mismatch adds exactly one to the count.
- R7: The error count saturates at all ones instead of wrapping.
- R8: The I and Q checkers keep separate lock flags and counts. A channel held at all ones never locks, while the ramp channel locks.
- R9: Dropping `chk_en` for one clock and raising it again clears lock and count, and the checker must see a new zero before it locks.
- R10: Cycles with `in_valid` low change neither the output data nor any checker state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | SAMPLE_W | Captured I sample |
| in_q | input | SAMPLE_W | Captured Q sample |
| mode_i | input | 2 | I source: 0 pass, 1 ramp, 2 ones, 3 pass |
| mode_q | input | 2 | Q source: 0 pass, 1 ramp, 2 ones, 3 pass |
| chk_en | input | 1 | Checker enable; a low level clears both checkers |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | SAMPLE_W | I sample after the source |
| out_q | output | SAMPLE_W | Q sample after the source |
| lock_i | output | 1 | I checker has locked onto the ramp |
| lock_q | output | 1 | Q checker has locked onto the ramp |
| err_i | output | ERR_W | I mismatch count, saturating |
| err_q | output | ERR_W | Q mismatch count, saturating |

## Verification
The bench builds the block with SAMPLE_W = 4 and ERR_W = 4. The four-bit sample space lets pass mode be swept over every code. The ramp wrap from 15 to 0 occurs within sixteen samples, both at the source and in the expected value of the checker. A four-bit count reaches saturation after fifteen mismatches, so the saturating behaviour, which is out of reach at 32 bits, runs in a few dozen cycles. Fixed sample sequences with known mismatch positions give the exact counts, including a skipped value that leaves the expected value out of step for good.

// File: rtl/iqpat_pkg.sv
package iqpat_pkg;
  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_RAMP = 2'd1,
    SRC_ONES = 2'd2,
    SRC_RSVD = 2'd3
  } src_mode_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/iqpat_source.sv
module iqpat_source
  import iqpat_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] raw,
  input  logic [1:0]          mode,
  output logic [SAMPLE_W-1:0] word
);
  localparam logic [SAMPLE_W-1:0] STEP = SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] ramp_q;
  logic [SAMPLE_W-1:0] pick;

  always_comb begin
    unique case (src_mode_e'(mode))
      SRC_RAMP: pick = ramp_q;
      SRC_ONES: pick = '1;
      default:  pick = raw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp_q <= '0;
      word   <= '0;
    end else begin
      if (src_mode_e'(mode) != SRC_RAMP) ramp_q <= '0;
      else if (take)                     ramp_q <= ramp_q + STEP;
      if (take) word <= pick;
    end
  end
endmodule

// File: rtl/iqpat_checker.sv
module iqpat_checker #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ERR_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                seen,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                locked,
  output logic [ERR_W-1:0]    errs
);
  localparam logic [SAMPLE_W-1:0] STEP  = SAMPLE_W'(1);
  localparam logic [ERR_W-1:0]    INC   = ERR_W'(1);
  localparam logic [ERR_W-1:0]    TOP   = '1;

  logic [SAMPLE_W-1:0] expect_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      locked   <= 1'b0;
      errs     <= '0;
      expect_q <= '0;
    end else if (seen) begin
      if (!locked) begin
        if (sample == '0) begin
          locked   <= 1'b1;
          expect_q <= STEP;
        end
      end else begin
        expect_q <= expect_q + STEP;
        if (sample != expect_q && errs != TOP) errs <= errs + INC;
      end
    end
  end
endmodule

// File: rtl/iq_pattern_path.sv
module iq_pattern_path
  import iqpat_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ERR_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          mode_q,
  input  logic                chk_en,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                lock_i,
  output logic                lock_q,
  output logic [ERR_W-1:0]    err_i,
  output logic [ERR_W-1:0]    err_q
);
  logic [NUM_CH-1:0][SAMPLE_W-1:0] raw_bus, word_bus;
  logic [NUM_CH-1:0][1:0]          mode_bus;
  logic [NUM_CH-1:0]               lock_bus;
  logic [NUM_CH-1:0][ERR_W-1:0]    err_bus;
  logic                            vld_q;

  assign raw_bus  = {in_q, in_i};
  assign mode_bus = {mode_q, mode_i};

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    iqpat_source #(.SAMPLE_W(SAMPLE_W)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (in_valid),
      .raw   (raw_bus[c]),
      .mode  (mode_bus[c]),
      .word  (word_bus[c])
    );
    iqpat_checker #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_chk (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (chk_en),
      .seen   (vld_q),
      .sample (word_bus[c]),
      .locked (lock_bus[c]),
      .errs   (err_bus[c])
    );
  end

  assign out_valid = vld_q;
  assign out_i     = word_bus[0];
  assign out_q     = word_bus[1];
  assign lock_i    = lock_bus[0];
  assign lock_q    = lock_bus[1];
  assign err_i     = err_bus[0];
  assign err_q     = err_bus[1];
endmodule

// File: rtl/iqpat_props.sv
module iqpat_props #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ERR_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                chk_en,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_i,
  input logic [SAMPLE_W-1:0] out_q,
  input logic                lock_i,
  input logic                lock_q,
  input logic [ERR_W-1:0]    err_i,
  input logic [ERR_W-1:0]    err_q
);
  localparam logic [ERR_W-1:0] TOP = '1;

  // R4
  idle_clear_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chk_en) |-> (!lock_i && err_i == '0));
  // R4
  idle_clear_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chk_en) |-> (!lock_q && err_q == '0));
  // R5
  zero_lock_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_i) |-> ($past(out_valid) && $past(out_i) == '0));
  // R5
  zero_lock_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(out_valid) && $past(out_q) == '0));
  // R6
  unit_step_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chk_en) |-> (err_i == $past(err_i) || err_i == $past(err_i) + ERR_W'(1)));
  // R6
  unit_step_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chk_en) |-> (err_q == $past(err_q) || err_q == $past(err_q) + ERR_W'(1)));
  // R7
  sat_hold_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chk_en) && $past(err_i) == TOP) |-> err_i == TOP);
  // R10
  idle_stable_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chk_en) && !$past(out_valid)) |-> ($stable(err_i) && $stable(lock_i)));
  // R10
  idle_stable_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chk_en) && !$past(out_valid)) |-> ($stable(err_q) && $stable(lock_q)));
endmodule

bind iq_pattern_path iqpat_props #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .chk_en    (chk_en),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q),
  .lock_i    (lock_i),
  .lock_q    (lock_q),
  .err_i     (err_i),
  .err_q     (err_q)
);

// File: tb/iq_pattern_path_test.sv
`timescale 1ns/1ps
module iq_pattern_path_test;
  localparam int BW = 4;
  localparam int BE = 4;
  localparam int ONES = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_i = '0, in_q = '0;
  logic [1:0]    mode_i = 2'd0, mode_q = 2'd0;
  logic          chk_en = 1'b0;
  logic          out_valid, lock_i, lock_q;
  logic [BW-1:0] out_i, out_q;
  logic [BE-1:0] err_i, err_q;

  int n_run = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  iq_pattern_path #(.SAMPLE_W(BW), .ERR_W(BE)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .mode_i(mode_i), .mode_q(mode_q), .chk_en(chk_en), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .lock_i(lock_i), .lock_q(lock_q),
    .err_i(err_i), .err_q(err_q)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input int a, input int b);
    in_valid = 1'b1;
    in_i = BW'(a);
    in_q = BW'(b);
    step();
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart();
    chk_en = 1'b0;
    step();
    check("R9 lock_i cleared", int'(lock_i), 0);
    check("R9 err_i cleared", int'(err_i), 0);
    chk_en = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    int seq_a[8] = '{7, 3, 0, 1, 2, 9, 4, 5};
    int seq_b[7] = '{0, 1, 2, 3, 5, 6, 7};
    step(); step();
    rst_n = 1'b1;
    step();
    check("R4 reset out_valid", int'(out_valid), 0);
    check("R4 reset lock_i", int'(lock_i), 0);
    check("R4 reset err_q", int'(err_q), 0);

    // R1: exhaustive pass-through sweep
    for (int v = 0; v <= ONES; v++) begin
      push(v, ONES - v);
      check("R1 pass out_i", int'(out_i), v);
      check("R1 pass out_q", int'(out_q), ONES - v);
      check("R1 out_valid", int'(out_valid), 1);
    end
    mode_i = 2'd3;
    push(6, 9);
    check("R1 code3 passes", int'(out_i), 6);
    // R10: idle cycle holds data
    in_i = 4'd1;
    step();
    check("R10 out_valid low", int'(out_valid), 0);
    check("R10 data held", int'(out_i), 6);

    // R4: zeros with checker disabled
    mode_i = 2'd0;
    push(0, 0); push(1, 1); step();
    check("R4 no lock while disabled", int'(lock_i), 0);

    // R3 and R2: ramp on I, ones on Q, checker enabled
    mode_i = 2'd1;
    mode_q = 2'd2;
    chk_en = 1'b1;
    step();
    for (int n = 0; n < 20; n++) begin
      push(n * 7, n * 3);
      check("R2 ramp out_i", int'(out_i), n % (ONES + 1));
      check("R3 ones out_q", int'(out_q), ONES);
      if (n % 3 == 0) begin
        step();
        check("R10 ramp held", int'(out_i), n % (ONES + 1));
      end
    end
    step();
    check("R5 ramp lane locked", int'(lock_i), 1);
    check("R6 clean ramp no errors", int'(err_i), 0);
    check("R8 ones lane unlocked", int'(lock_q), 0);
    check("R8 ones lane count", int'(err_q), 0);

    // R8: swap lanes
    mode_i = 2'd2;
    mode_q = 2'd1;
    restart();
    step();
    for (int n = 0; n < 18; n++) push(n, n);
    step();
    check("R8 swapped q locked", int'(lock_q), 1);
    check("R8 swapped q errors", int'(err_q), 0);
    check("R8 swapped i unlocked", int'(lock_i), 0);

    // R5/R6: pass mode, pre-lock junk and one glitch
    mode_i = 2'd0;
    mode_q = 2'd0;
    restart();
    push(seq_a[0], ONES); push(seq_a[1], ONES); step();
    check("R5 no lock before zero", int'(lock_i), 0);
    check("R5 no errors before lock", int'(err_i), 0);
    for (int k = 2; k < 8; k++) push(seq_a[k], ONES);
    step();
    check("R6 single glitch", int'(err_i), 1);
    check("R5 locked after zero", int'(lock_i), 1);
    check("R8 q unlocked", int'(lock_q), 0);

    // R6: skipped value keeps expected out of step
    restart();
    for (int k = 0; k < 7; k++) push(seq_b[k], ONES);
    step();
    check("R6 skip counts three", int'(err_i), 3);
    // R10: invalid garbage ignored
    in_i = 4'd3;
    step(); step(); step();
    check("R10 invalid ignored", int'(err_i), 3);

    // R7: saturation
    restart();
    push(0, ONES);
    for (int k = 1; k <= 10; k++) push(0, ONES);
    step();
    check("R6 ten mismatches", int'(err_i), 10);
    for (int k = 11; k <= 20; k++) push(0, ONES);
    step();
    check("R7 saturated", int'(err_i), (1 << BE) - 1);

    // R9: restart clears and needs a fresh zero
    restart();
    push(5, ONES); push(6, ONES); step();
    check("R9 relock needs zero", int'(lock_i), 0);
    check("R9 count restarted", int'(err_i), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule